// File: doc/BRIEF.md
# Power-Frame Phase Sequencer with Manchester Encoder

This block runs on the primary side of an isolated supply whose transformer also carries serial data in both directions. It repeats a fixed frame made of two phases. In the power phase the half-bridge command line is driven from Manchester-coded bits, so the transformer receives energy and forward data together. In the listen phase both primary switches are held off and the damping loads are switched in, so the secondary side can answer with pulses through the same transformer.

Each power phase opens with a short run of 1 bits that the far end can lock its clock to. After that, bits come from a valid/ready stream. When no bit is pending, an idle fill bit is sent instead, so the line never stops toggling while power is delivered. A bit is only taken from the stream when it can be sent in full before the listen phase. Any leftover fraction of a bit slot at the end of the power phase carries a cut-short fill bit. A one-cycle marker flags the first cycle of every listen phase for the reverse-channel receiver.

All timing is counted in clock cycles. The defaults assume a 100 MHz clock: a 500 ns half bit, a 1 ms frame and an 11 us listen phase.

Top module: `pwr_frame_seq`

## Requirements
- R1: While `rst` is high, and on the first output cycle after it, `cmd`, `en_n`, `listen` and `listen_start` are all 0. The frame restarts from its first power cycle when `rst` falls.
- R2: The frame lasts FRAME_CYC cycles. Its last LISTEN_CYC cycles form the listen phase, in which `listen`=1, `en_n`=0 and `cmd`=0.
- R3: Throughout the power phase (the first FRAME_CYC-LISTEN_CYC cycles), `en_n`=1 and `listen`=0.
- R4: Each power-phase bit slot lasts 2*HALF_CYC cycles. A 1 is sent as `cmd` high for HALF_CYC cycles and then low for HALF_CYC cycles. A 0 is sent as low and then high.
- R5: The first PRE_BITS slots of every power phase carry 1 bits whatever the inputs are, and `tx_ready` is 0 during them.
- R6: `tx_ready` is 1 only in the first cycle of a slot past the preamble that ends within the power phase. A bit presented with `tx_valid`=1 in that cycle is accepted and sent in that slot. Bits that do not fit are left for the next frame.
- R7: A full slot past the preamble in which no bit is accepted carries `idle_bit`, sampled at the first cycle of the slot.
- R8: If the power phase is not a whole number of slots, the leftover slot sends the first part of an `idle_bit` Manchester bit and never accepts data.
- R9: `listen_start` is high for exactly one cycle, the first cycle of each listen phase.
- R10: All outputs except `tx_ready` are registered and lag the internal frame position by one cycle. `tx_ready` is decoded directly from registered state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; defaults assume 100 MHz |
| rst | input | 1 | Synchronous active-high reset |
| tx_valid | input | 1 | A forward data bit is offered |
| tx_bit | input | 1 | Forward data bit value |
| idle_bit | input | 1 | Fill bit sent when no data bit is taken |
| tx_ready | output | 1 | Block takes `tx_bit` at this edge if `tx_valid` |
| cmd | output | 1 | Half-bridge command, Manchester-coded |
| en_n | output | 1 | Active-low enable; low turns off both switches and connects the loads |
| listen | output | 1 | High during the listen phase |
| listen_start | output | 1 | One-cycle marker at the start of the listen phase |

## Verification
The assertions assume that the parameters describe a real frame: HALF_CYC of at least 1, a listen phase shorter than the frame, and a power phase long enough for the preamble. They also assume that reset is held for at least one clock edge. The mid-bit toggle and preamble checks only apply once an output cycle has passed since reset, because the outputs hold reset values until then. The stimulus drives the inputs half a cycle away from the active edge. It keeps `tx_bit` stable while it is offered, changes `idle_bit` only at frame boundaries, and uses short frame parameters, so that preamble, data, fill, tail and listen slots all appear within a few frames.

// File: rtl/pwr_frame_pkg.sv
package pwr_frame_pkg;
  typedef enum logic {
    PH_POWER  = 1'b0,
    PH_LISTEN = 1'b1
  } phase_e;
endpackage

// File: rtl/pwr_frame_timer.sv
// Frame position counters: cycle in frame, cycle in bit slot, slot index.
module pwr_frame_timer #(
  parameter int FRAME_CYC  = 100000,
  parameter int LISTEN_CYC = 1100,
  parameter int HALF_CYC   = 50,
  parameter int SLOT_W     = 10
) (
  input  logic                  clk,
  input  logic                  rst,
  output pwr_frame_pkg::phase_e phase,
  output logic                  slot_start,
  output logic                  first_half,
  output logic                  mid_bit,
  output logic                  listen_first,
  output logic [SLOT_W-1:0]     slot
);
  import pwr_frame_pkg::*;

  localparam int BIT_CYC   = 2 * HALF_CYC;
  localparam int POWER_CYC = FRAME_CYC - LISTEN_CYC;
  localparam int FW        = $clog2(FRAME_CYC + 1);
  localparam int BW        = $clog2(BIT_CYC + 1);

  logic [FW-1:0]     fcnt_q;
  logic [BW-1:0]     bcnt_q;
  logic [SLOT_W-1:0] slot_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      fcnt_q <= '0;
      bcnt_q <= '0;
      slot_q <= '0;
    end else if (fcnt_q == FW'(FRAME_CYC - 1)) begin
      fcnt_q <= '0;
      bcnt_q <= '0;
      slot_q <= '0;
    end else begin
      fcnt_q <= fcnt_q + 1'b1;
      if (bcnt_q == BW'(BIT_CYC - 1)) begin
        bcnt_q <= '0;
        slot_q <= slot_q + 1'b1;
      end else begin
        bcnt_q <= bcnt_q + 1'b1;
      end
    end
  end

  always_comb begin
    phase        = (fcnt_q >= FW'(POWER_CYC)) ? PH_LISTEN : PH_POWER;
    slot_start   = (bcnt_q == '0);
    first_half   = (bcnt_q < BW'(HALF_CYC));
    mid_bit      = (bcnt_q == BW'(HALF_CYC));
    listen_first = (fcnt_q == FW'(POWER_CYC));
    slot         = slot_q;
  end

  // R2: a listen phase only ends by restarting the frame at slot 0
  a_r2_listen_exit: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_LISTEN) |=> (phase == PH_LISTEN || (slot_q == '0 && slot_start)));
endmodule

// File: rtl/pwr_manch_enc.sv
// Manchester level generator: 1 = high then low, 0 = low then high.
module pwr_manch_enc (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic slot_start,
  input  logic first_half,
  input  logic mid_bit,
  input  logic new_bit,
  input  logic started,
  output logic cmd
);
  logic cur_q;
  logic cmd_q;
  logic bit_now;
  logic lvl;

  always_comb begin
    bit_now = slot_start ? new_bit : cur_q;
    lvl     = run ? (first_half ? bit_now : ~bit_now) : 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q <= 1'b0;
      cmd_q <= 1'b0;
    end else begin
      cur_q <= bit_now;
      cmd_q <= lvl;
    end
  end

  assign cmd = cmd_q;

  // R4: the line flips at every mid-bit point of the power phase
  a_r4_mid_flip: assert property (@(posedge clk) disable iff (rst)
    (started && run && mid_bit) |=> (cmd_q != $past(cmd_q)));
endmodule

// File: rtl/pwr_frame_seq.sv
// Primary-side frame sequencer: power phase with Manchester data, then listen phase.
module pwr_frame_seq #(
  parameter int HALF_CYC   = 50,
  parameter int FRAME_CYC  = 100000,
  parameter int LISTEN_CYC = 1100,
  parameter int PRE_BITS   = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tx_valid,
  input  logic tx_bit,
  input  logic idle_bit,
  output logic tx_ready,
  output logic cmd,
  output logic en_n,
  output logic listen,
  output logic listen_start
);
  import pwr_frame_pkg::*;

  localparam int BIT_CYC   = 2 * HALF_CYC;
  localparam int POWER_CYC = FRAME_CYC - LISTEN_CYC;
  localparam int FULL_BITS = POWER_CYC / BIT_CYC;
  localparam int SLOT_W    = $clog2(FRAME_CYC / BIT_CYC + 2);

  phase_e            phase;
  logic              slot_start, first_half, mid_bit, listen_first;
  logic [SLOT_W-1:0] slot;
  logic              power, in_pre, fits, take, new_bit;
  logic              en_n_q, listen_q, lstart_q, started_q;

  pwr_frame_timer #(
    .FRAME_CYC (FRAME_CYC),
    .LISTEN_CYC(LISTEN_CYC),
    .HALF_CYC  (HALF_CYC),
    .SLOT_W    (SLOT_W)
  ) timer_i (
    .clk         (clk),
    .rst         (rst),
    .phase       (phase),
    .slot_start  (slot_start),
    .first_half  (first_half),
    .mid_bit     (mid_bit),
    .listen_first(listen_first),
    .slot        (slot)
  );

  always_comb begin
    power    = (phase == PH_POWER);
    in_pre   = (slot < SLOT_W'(PRE_BITS));
    fits     = (slot < SLOT_W'(FULL_BITS));
    tx_ready = power && slot_start && !in_pre && fits;
    take     = tx_ready && tx_valid;
    new_bit  = in_pre ? 1'b1 : (take ? tx_bit : idle_bit);
  end

  pwr_manch_enc enc_i (
    .clk       (clk),
    .rst       (rst),
    .run       (power),
    .slot_start(slot_start),
    .first_half(first_half),
    .mid_bit   (mid_bit),
    .new_bit   (new_bit),
    .started   (started_q),
    .cmd       (cmd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      en_n_q    <= 1'b0;
      listen_q  <= 1'b0;
      lstart_q  <= 1'b0;
      started_q <= 1'b0;
    end else begin
      en_n_q    <= power;
      listen_q  <= !power;
      lstart_q  <= listen_first;
      started_q <= 1'b1;
    end
  end

  assign en_n         = en_n_q;
  assign listen       = listen_q;
  assign listen_start = lstart_q;

  // R2: listen phase keeps both switches off and the command low
  a_r2_listen_quiet: assert property (@(posedge clk) disable iff (rst)
    listen_q |-> (!en_n_q && !cmd));
  // R3: power phase keeps the switches enabled
  a_r3_power_enabled: assert property (@(posedge clk) disable iff (rst)
    (started_q && !listen_q) |-> en_n_q);
  // R9: listen marker is one cycle wide and inside the listen phase
  a_r9_marker_single: assert property (@(posedge clk) disable iff (rst)
    lstart_q |=> !lstart_q);
  a_r9_marker_in_listen: assert property (@(posedge clk) disable iff (rst)
    lstart_q |-> listen_q);
  // R6: ready never lasts two cycles, since a slot is at least two cycles long
  a_r6_ready_single: assert property (@(posedge clk) disable iff (rst)
    tx_ready |=> !tx_ready);
  // R5: a preamble slot starts with the line high
  a_r5_preamble_high: assert property (@(posedge clk) disable iff (rst)
    (started_q && power && slot_start && in_pre) |=> cmd);
endmodule

// File: tb/pwr_frame_seq_tb_top.sv
module pwr_frame_seq_tb_top;
  localparam int HALF   = 2;
  localparam int BITC   = 2 * HALF;
  localparam int FRAME  = 64;
  localparam int LISTEN = 14;
  localparam int PRE    = 2;
  localparam int POWER  = FRAME - LISTEN;   // 50
  localparam int FULL   = POWER / BITC;     // 12, tail slot 12 covers cycles 48..49

  // checkpoint table for the first frame, no data, idle_bit=0: {cycle[5:0], cmd, en_n, listen}
  localparam logic [8:0] TBL [12] = '{
    {6'd0,  3'b110}, {6'd1,  3'b110}, {6'd2,  3'b010}, {6'd3,  3'b010},
    {6'd4,  3'b110}, {6'd6,  3'b010}, {6'd8,  3'b010}, {6'd10, 3'b110},
    {6'd47, 3'b110}, {6'd48, 3'b010}, {6'd50, 3'b001}, {6'd63, 3'b001}};

  logic clk = 1'b0;
  logic rst, tx_valid, tx_bit, idle_bit;
  logic tx_ready, cmd, en_n, listen, listen_start;

  int tests, fails, fc, last_fc, dlen, dptr;
  logic mbit;
  string mtag;
  logic [31:0] dq;

  always #5 clk = ~clk;

  pwr_frame_seq #(
    .HALF_CYC(HALF), .FRAME_CYC(FRAME), .LISTEN_CYC(LISTEN), .PRE_BITS(PRE)
  ) dut_i (
    .clk(clk), .rst(rst), .tx_valid(tx_valid), .tx_bit(tx_bit), .idle_bit(idle_bit),
    .tx_ready(tx_ready), .cmd(cmd), .en_n(en_n), .listen(listen),
    .listen_start(listen_start)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, last_fc);
    end
  endtask

  // one clock: drive inputs, check ready, advance, check registered outputs
  task automatic step();
    bit pw, rdy;
    int bc, sl;
    logic lvl;
    pw  = (fc < POWER);
    bc  = fc % BITC;
    sl  = fc / BITC;
    rdy = pw && bc == 0 && sl >= PRE && sl < FULL;
    tx_valid = (dptr < dlen);
    tx_bit   = dq[dptr];
    chk(tx_ready == rdy, "R6 ready", int'(tx_ready), int'(rdy));
    if (pw && bc == 0) begin
      if (sl < PRE) begin mbit = 1'b1; mtag = "R5 preamble"; end
      else if (rdy && tx_valid) begin mbit = tx_bit; mtag = "R4 data"; end
      else if (sl >= FULL) begin mbit = idle_bit; mtag = "R8 tail"; end
      else begin mbit = idle_bit; mtag = "R7 idle fill"; end
    end
    if (rdy && tx_valid) dptr++;
    lvl = pw ? ((bc < HALF) ? mbit : ~mbit) : 1'b0;
    @(posedge clk); #1;
    last_fc = fc;
    chk(cmd == lvl, pw ? mtag : "R2 cmd low", int'(cmd), int'(lvl));
    chk(en_n == pw, pw ? "R3 enable" : "R2 enable", int'(en_n), int'(pw));
    chk(listen == !pw, pw ? "R3 listen" : "R2 listen", int'(listen), int'(!pw));
    chk(listen_start == (fc == POWER), "R9 marker", int'(listen_start), int'(fc == POWER));
    fc = (fc + 1) % FRAME;
  endtask

  initial begin
    #2000000;
    tests++; fails++;
    $display("FAIL watchdog expired actual=hang expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    tests = 0; fails = 0; fc = 0; last_fc = 0; dlen = 0; dptr = 0;
    mbit = 1'b0; mtag = "";
    dq = 32'd0;
    rst = 1'b1; tx_valid = 1'b0; tx_bit = 1'b0; idle_bit = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    // R1: outputs held at zero in reset
    chk({cmd, en_n, listen, listen_start} == 4'b0, "R1 reset outputs",
        int'({cmd, en_n, listen, listen_start}), 0);
    rst = 1'b0;

    // table walk over the first frame (R10 latency is built into the cycle numbering)
    for (int i = 0; i < 12; i++) begin
      do step(); while (last_fc != int'(TBL[i][8:3]));
      chk(cmd == TBL[i][2], "R4 table cmd", int'(cmd), int'(TBL[i][2]));
      chk(en_n == TBL[i][1], "R3 table en_n", int'(en_n), int'(TBL[i][1]));
      chk(listen == TBL[i][0], "R2 table listen", int'(listen), int'(TBL[i][0]));
    end

    // data frames: 13 bits queued, 10 data slots per frame, fill bit 1
    idle_bit = 1'b1;
    dq = 32'b1_0110_0111_0100;
    dlen = 13; dptr = 0;
    repeat (FRAME) step();
    chk(dptr == 10, "R6 bits taken in one frame", dptr, 10);
    repeat (FRAME) step();
    chk(dptr == 13, "R6 leftover bits taken next frame", dptr, 13);

    // all-zero data with fill 0, then no data: R7 fill and R8 tail with a 0
    idle_bit = 1'b0;
    dq = 32'd0; dlen = 4; dptr = 0;
    repeat (FRAME) step();
    chk(dptr == 4, "R6 zero bits taken", dptr, 4);

    // reset in mid-frame restarts the frame
    repeat (20) step();
    rst = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    chk({cmd, en_n, listen, listen_start} == 4'b0, "R1 mid-run reset outputs",
        int'({cmd, en_n, listen, listen_start}), 0);
    chk(tx_ready == 1'b0, "R1 no ready in reset preamble", int'(tx_ready), 0);
    rst = 1'b0;
    fc = 0;
    idle_bit = 1'b1;
    dq = 32'b101; dlen = 3; dptr = 0;
    repeat (FRAME + 4) step();
    chk(dptr == 3, "R1 frame restart accepts data", dptr, 3);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule